// File: doc/BRIEF.md
# Lane Marker Transcoding Decoder

This block sits on the receive side of a 512B/513B transcoder. It takes one 513-bit transcoded block and returns the eight 66-bit codewords the block carries, in their original order. The block's flag bit selects the layout. When the flag is clear, the eight 64-bit rows are plain data. When the flag is set, the leading rows may be tagged lane-alignment-marker rows, chained by a continuation bit.

Each marker row names the slot (0 to 7) where its marker originally sat. The decoder rebuilds the full 66-bit marker in that slot. The marker's check bytes are restored as complements of its identity bytes and of a parity byte supplied by the caller. The remaining data rows fill the unclaimed slots in row order.

Blocks enter through a valid/ready handshake. Codewords leave one per handshake on a valid/ready stream. A new block is taken only after the eighth codeword of the current one has been handed over.

Top module: `lane_mark_dec`

## Requirements
- R1: Layout. Bit 0 of `in_blk` is the flag. Row r is `in_blk[1+64r +: 64]`, and byte k of a row is bits `[8k+7:8k]`. An output codeword carries its sync header in bits [65:64] and its payload in bits [63:0]. With the flag at 0, slot r carries row r unchanged with sync header 2'b01, whatever the row contents are.
- R2: With the flag at 1, row 0 is a marker row when its bits [7:4] equal 4'b0100. If row 0 fails that test, no row is a marker, and all eight rows are data as in R1.
- R3: The marker built from a marker row appears in the slot given by bits [3:1] of that row.
- R4: A rebuilt marker has sync header 2'b10. Payload bytes 0..2 are row bytes 1..3. Byte 3 is `in_bip` byte i, where i is the marker's row index. Bytes 4..6 are the complements of bytes 0..2, and byte 7 is the complement of byte 3.
- R5: Rows after the last marker row are data rows. They fill the slots that no kept marker claims, lowest slot first, in row order, each with sync header 2'b01.
- R6: After a block is accepted, `out_valid` rises on the next cycle and slots 0..7 are delivered one per `out_valid && out_ready` cycle. While `out_ready` is low, `out_cw` holds its value. `in_ready` stays low until slot 7 has been taken.
- R7: If a marker row names a slot already claimed by an earlier marker row, the later row is dropped. `dup_err` is 1 from the cycle after acceptance until the next acceptance. A slot that is left with no data row carries sync 2'b01 and an all-zero payload.
- R8: Under reset, or in the cycle after reset, `out_valid` and `dup_err` are 0 and `in_ready` is 1, including when reset arrives in the middle of a block.
- R9: Row i+1 is a marker row only if row i is a marker row, bit 0 of row i is 1, and row i+1 passes the type test. A clear bit 0 ends the chain, even if the following row has type 4'b0100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Transcoded block offered |
| in_ready | output | 1 | Decoder can take a block |
| in_blk | input | 513 | Flag bit and eight 64-bit rows |
| in_bip | input | 64 | Egress parity byte for each row index |
| out_valid | output | 1 | Codeword present on `out_cw` |
| out_ready | input | 1 | Downstream takes the codeword |
| out_cw | output | 66 | Sync header [65:64] and payload [63:0] |
| dup_err | output | 1 | Current block had two markers on one slot |

## Verification
The stimulus targets several failure modes, each with a visible symptom:
- A block holding eight markers in reversed slot order. A decoder that placed markers by row index instead of slot field would emit them in the wrong order.
- A chain whose continuation bit is clear ahead of a row that still carries the marker type. A decoder that ignored the bit would turn a data row into a marker.
- A chain cut by a row whose type is not the marker type. This also checks that later data rows do not shift.
- A duplicated slot. Keeping the wrong row, or leaving the spare slot unfilled, shows as wrong payloads and a missing zero codeword.
- Downstream stalls and a reset in mid-block. These expose a decoder that lets `out_cw` drift, takes a new block early, or keeps a stale error flag.

// File: rtl/lmd_pkg.sv
package lmd_pkg;
  localparam logic [3:0] LMD_MK_TYPE   = 4'b0100;
  localparam logic [1:0] LMD_SYNC_DATA = 2'b01;
  localparam logic [1:0] LMD_SYNC_CTRL = 2'b10;

  // Rebuild the 64-bit marker payload from identity bytes and parity byte.
  function automatic logic [63:0] lmd_mk_word(input logic [23:0] ident,
                                              input logic [7:0]  par);
    return {~par, ~ident, par, ident};
  endfunction
endpackage

// File: rtl/lmd_row_parse.sv
module lmd_row_parse
  import lmd_pkg::*;
#(
  parameter int NSLOT = 8,
  parameter int POSW  = 3
) (
  input  logic                  flag_i,
  input  logic [NSLOT*8-1:0]    hdr_i,
  output logic [NSLOT-1:0]      is_mk_o,
  output logic [NSLOT-1:0]      keep_o,
  output logic [NSLOT*POSW-1:0] pos_o,
  output logic [POSW:0]         nmk_o,
  output logic                  dup_o
);
  logic [NSLOT-1:0] type_ok;
  logic [NSLOT-1:0] cont;

  genvar g;
  generate
    for (g = 0; g < NSLOT; g++) begin : g_hdr
      assign type_ok[g]             = (hdr_i[g*8+4 +: 4] == LMD_MK_TYPE);
      assign cont[g]                = hdr_i[g*8];
      assign pos_o[g*POSW +: POSW]  = hdr_i[g*8+1 +: POSW];
    end
  endgenerate

  always_comb begin
    is_mk_o = '0;
    keep_o  = '0;
    nmk_o   = '0;
    dup_o   = 1'b0;
    for (int i = 0; i < NSLOT; i++) begin
      if (i == 0) is_mk_o[i] = flag_i & type_ok[i];
      else        is_mk_o[i] = is_mk_o[i-1] & cont[i-1] & type_ok[i];
      keep_o[i] = is_mk_o[i];
      for (int j = 0; j < i; j++) begin
        if (is_mk_o[j] && (pos_o[j*POSW +: POSW] == pos_o[i*POSW +: POSW]))
          keep_o[i] = 1'b0;
      end
      if (is_mk_o[i]) begin
        nmk_o = nmk_o + {{POSW{1'b0}}, 1'b1};
        if (!keep_o[i]) dup_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/lmd_slot_map.sv
module lmd_slot_map #(
  parameter int NSLOT = 8,
  parameter int POSW  = 3
) (
  input  logic [NSLOT-1:0]          keep_i,
  input  logic [NSLOT*POSW-1:0]     pos_i,
  output logic [NSLOT-1:0]          claim_o,
  output logic [NSLOT*POSW-1:0]     src_o,
  output logic [NSLOT*(POSW+1)-1:0] fill_o
);
  logic [POSW:0] free_cnt;

  always_comb begin
    claim_o  = '0;
    src_o    = '0;
    fill_o   = '0;
    free_cnt = '0;
    for (int s = 0; s < NSLOT; s++) begin
      for (int i = NSLOT - 1; i >= 0; i--) begin
        if (keep_i[i] && (pos_i[i*POSW +: POSW] == POSW'(s))) begin
          claim_o[s]            = 1'b1;
          src_o[s*POSW +: POSW] = POSW'(i);
        end
      end
      fill_o[s*(POSW+1) +: (POSW+1)] = free_cnt;
      if (!claim_o[s]) free_cnt = free_cnt + {{POSW{1'b0}}, 1'b1};
    end
  end
endmodule

// File: rtl/lmd_assemble.sv
module lmd_assemble
  import lmd_pkg::*;
#(
  parameter int NSLOT = 8,
  parameter int ROWW  = 64,
  parameter int POSW  = 3,
  parameter int CWW   = ROWW + 2
) (
  input  logic [NSLOT*ROWW-1:0]     rows_i,
  input  logic [NSLOT*8-1:0]        bip_i,
  input  logic [NSLOT-1:0]          claim_i,
  input  logic [NSLOT*POSW-1:0]     src_i,
  input  logic [NSLOT*(POSW+1)-1:0] fill_i,
  input  logic [POSW:0]             nmk_i,
  output logic [NSLOT*CWW-1:0]      cw_o
);
  genvar s;
  generate
    for (s = 0; s < NSLOT; s++) begin : g_slot
      logic [POSW-1:0] src;
      logic [ROWW-1:0] mrow;
      logic [7:0]      par;
      logic [POSW+1:0] didx;
      logic [ROWW-1:0] drow;

      always_comb begin
        src  = src_i[s*POSW +: POSW];
        mrow = rows_i[int'(src)*ROWW +: ROWW];
        par  = bip_i[int'(src)*8 +: 8];
        didx = {1'b0, nmk_i} + {1'b0, fill_i[s*(POSW+1) +: (POSW+1)]};
        drow = '0;
        if (didx < (POSW+2)'(NSLOT))
          drow = rows_i[int'(didx)*ROWW +: ROWW];
        if (claim_i[s])
          cw_o[s*CWW +: CWW] = {LMD_SYNC_CTRL, lmd_mk_word(mrow[31:8], par)};
        else
          cw_o[s*CWW +: CWW] = {LMD_SYNC_DATA, drow};
      end
    end
  endgenerate
endmodule

// File: rtl/lane_mark_dec.sv
module lane_mark_dec #(
  parameter  int NSLOT = 8,
  parameter  int ROWW  = 64,
  localparam int POSW  = $clog2(NSLOT),
  localparam int CWW   = ROWW + 2,
  localparam int BLKW  = NSLOT * ROWW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BLKW-1:0]   in_blk,
  input  logic [NSLOT*8-1:0] in_bip,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CWW-1:0]    out_cw,
  output logic              dup_err
);
  logic [NSLOT*ROWW-1:0]     rows;
  logic [NSLOT*8-1:0]        hdr;
  logic [NSLOT-1:0]          is_mk, keep, claim;
  logic [NSLOT*POSW-1:0]     pos, src;
  logic [NSLOT*(POSW+1)-1:0] fill;
  logic [POSW:0]             nmk;
  logic                      dup;
  logic [NSLOT*CWW-1:0]      cw_all;

  assign rows = in_blk[BLKW-1:1];

  genvar g;
  generate
    for (g = 0; g < NSLOT; g++) begin : g_hdr
      assign hdr[g*8 +: 8] = rows[g*ROWW +: 8];
    end
  endgenerate

  lmd_row_parse #(.NSLOT(NSLOT), .POSW(POSW)) u_parse (
    .flag_i (in_blk[0]),
    .hdr_i  (hdr),
    .is_mk_o(is_mk),
    .keep_o (keep),
    .pos_o  (pos),
    .nmk_o  (nmk),
    .dup_o  (dup)
  );

  lmd_slot_map #(.NSLOT(NSLOT), .POSW(POSW)) u_map (
    .keep_i (keep),
    .pos_i  (pos),
    .claim_o(claim),
    .src_o  (src),
    .fill_o (fill)
  );

  lmd_assemble #(.NSLOT(NSLOT), .ROWW(ROWW), .POSW(POSW), .CWW(CWW)) u_asm (
    .rows_i (rows),
    .bip_i  (in_bip),
    .claim_i(claim),
    .src_i  (src),
    .fill_i (fill),
    .nmk_i  (nmk),
    .cw_o   (cw_all)
  );

  logic [CWW-1:0]  slot_mem [NSLOT];
  logic            busy_q;
  logic [POSW-1:0] slot_q;
  logic [CWW-1:0]  cw_q;
  logic            err_q;
  logic            accept, take, last;
  logic [POSW-1:0] next_slot;

  assign accept    = in_valid && !busy_q;
  assign take      = busy_q && out_ready;
  assign last      = (slot_q == POSW'(NSLOT - 1));
  assign next_slot = slot_q + POSW'(1);

  always_ff @(posedge clk) begin
    if (accept) begin
      for (int s = 0; s < NSLOT; s++) slot_mem[s] <= cw_all[s*CWW +: CWW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      slot_q <= '0;
      cw_q   <= '0;
      err_q  <= 1'b0;
    end else if (accept) begin
      busy_q <= 1'b1;
      slot_q <= '0;
      cw_q   <= cw_all[CWW-1:0];
      err_q  <= dup;
    end else if (take) begin
      if (last) begin
        busy_q <= 1'b0;
      end else begin
        slot_q <= next_slot;
        cw_q   <= slot_mem[next_slot];
      end
    end
  end

  assign in_ready  = !busy_q;
  assign out_valid = busy_q;
  assign out_cw    = cw_q;
  assign dup_err   = err_q;

  logic unused_mk;
  assign unused_mk = ^is_mk;
endmodule

// File: rtl/lane_mark_dec_chk.sv
module lane_mark_dec_chk #(
  parameter int NSLOT = 8,
  parameter int CWW   = 66
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic           in_ready,
  input logic           out_valid,
  input logic           out_ready,
  input logic [CWW-1:0] out_cw,
  input logic           dup_err
);
  localparam int CW = $clog2(NSLOT + 1);
  logic [CW-1:0] taken;

  always_ff @(posedge clk) begin
    if (rst) taken <= '0;
    else if (in_valid && in_ready) taken <= '0;
    else if (out_valid && out_ready) taken <= taken + CW'(1);
  end

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_cw));

  // R6
  busy_block_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  // R6
  accept_start_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);

  // R6
  slot_count_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready |-> taken < CW'(NSLOT));

  // R6
  block_end_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && taken == CW'(NSLOT - 1) |=> !out_valid);

  // R4
  mk_check_bytes_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_cw[CWW-1:CWW-2] == 2'b10 |->
      out_cw[63:32] == ~out_cw[31:0]);

  // R1
  sync_legal_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_cw[CWW-1:CWW-2] == 2'b01 || out_cw[CWW-1:CWW-2] == 2'b10));

  // R7
  err_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) |=> $stable(dup_err));
endmodule

bind lane_mark_dec lane_mark_dec_chk #(.NSLOT(NSLOT), .CWW(CWW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_cw   (out_cw),
  .dup_err  (dup_err)
);

// File: tb/lane_mark_dec_tb.sv
module lane_mark_dec_tb;
  localparam int BLKW = 513;
  localparam int NV   = 8;

  typedef struct packed {
    logic        flag;
    logic [7:0]  mk;
    logic [7:0]  fc;
    logic [23:0] pos;
    logic [7:0]  seed;
    logic        exp_err;
  } vec_t;

  // flag, marker-row mask, continuation bits, slot fields (3 bits per row), seed, expected error
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'hFF, 8'hFF, 24'h053977, 8'h11, 1'b0},  // R1 flag clear: all rows data
    '{1'b1, 8'h01, 8'h00, 24'h000005, 8'h22, 1'b0},  // R3 single marker at slot 5
    '{1'b1, 8'h07, 8'h03, 24'h0000C7, 8'h33, 1'b0},  // R5 three markers at 7,0,3
    '{1'b1, 8'h03, 8'h01, 24'h000012, 8'h44, 1'b1},  // R7 two markers on slot 2
    '{1'b1, 8'h03, 8'h00, 24'h00000C, 8'h55, 1'b0},  // R9 chain stops at row 0
    '{1'b1, 8'h00, 8'h00, 24'h000000, 8'h66, 1'b0},  // R2 no marker type in row 0
    '{1'b1, 8'hFF, 8'h7F, 24'h053977, 8'h77, 1'b0},  // R3 eight markers reversed
    '{1'b1, 8'h05, 8'h01, 24'h000046, 8'h88, 1'b0}   // R2 chain cut by wrong type
  };

  logic             clk, rst;
  logic             in_valid, in_ready;
  logic [BLKW-1:0]  in_blk;
  logic [63:0]      in_bip;
  logic             out_valid, out_ready;
  logic [65:0]      out_cw;
  logic             dup_err;

  int nchk  = 0;
  int nfail = 0;

  lane_mark_dec u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_blk(in_blk), .in_bip(in_bip), .out_valid(out_valid),
    .out_ready(out_ready), .out_cw(out_cw), .dup_err(dup_err)
  );

  initial begin
    clk = 1'b0;
    forever #5 clk = ~clk;
  end

  task automatic chk(input bit ok, input string req, input logic [65:0] act,
                     input logic [65:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string vtag(input int v);
    case (v)
      0: return "R1";
      1: return "R3";
      2: return "R5";
      3: return "R7";
      4: return "R9";
      5: return "R2";
      6: return "R3";
      default: return "R2";
    endcase
  endfunction

  task automatic build(input vec_t t, output logic [BLKW-1:0] blk,
                       output logic [63:0] bip);
    blk = '0;
    bip = '0;
    for (int i = 0; i < 8; i++) begin
      logic [63:0] row;
      row = 64'h9E3779B97F4A7C15 * 64'(t.seed * 8 + i + 1);
      if (t.mk[i]) row[7:0] = {4'h4, t.pos[3*i +: 3], t.fc[i]};
      else if (row[7:4] == 4'h4) row[7:4] = 4'h5;
      blk[1+64*i +: 64] = row;
      bip[8*i +: 8] = t.seed ^ 8'(i * 37);
    end
    blk[0] = t.flag;
  endtask

  task automatic model(input logic [BLKW-1:0] blk, input logic [63:0] bip,
                       output logic [65:0] e [8]);
    logic [63:0] r [8];
    int n, dp, f;
    for (int i = 0; i < 8; i++) r[i] = blk[1+64*i +: 64];
    n = 0;
    if (blk[0]) begin
      while (n < 8 && r[n][7:4] == 4'h4) begin
        n++;
        if (!r[n-1][0]) break;
      end
    end
    dp = n;
    for (int s = 0; s < 8; s++) begin
      f = -1;
      for (int i = 0; i < n; i++)
        if (f < 0 && r[i][3:1] == 3'(s)) f = i;
      if (f >= 0)
        e[s] = {2'b10, ~bip[8*f +: 8], ~r[f][31:8], bip[8*f +: 8], r[f][31:8]};
      else if (dp < 8) begin
        e[s] = {2'b01, r[dp]};
        dp++;
      end else
        e[s] = {2'b01, 64'h0};
    end
  endtask

  task automatic run_vec(input vec_t t, input int v);
    logic [BLKW-1:0] blk;
    logic [63:0]     bip;
    logic [65:0]     exp [8];
    logic [65:0]     held;
    logic            stalled, err_seen;
    int              cnt, cyc;
    string           tg;
    build(t, blk, bip);
    model(blk, bip, exp);
    tg = vtag(v);
    @(negedge clk);
    in_blk = blk; in_bip = bip; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    cnt = 0; cyc = 0; stalled = 1'b0; err_seen = 1'b0;
    while (cnt < 8 && cyc < 200) begin
      @(negedge clk);
      in_valid = 1'b0;
      if (stalled)
        chk(out_cw == held, $sformatf("R6 stall hold vec%0d", v), out_cw, held);
      out_ready = (v == 0) ? 1'b1 : (((cyc + v) % 3) != 0);
      chk(out_valid && !in_ready, $sformatf("R6 busy vec%0d", v),
          {64'h0, out_valid, in_ready}, 66'h2);
      if (!err_seen) begin
        chk(dup_err == t.exp_err, $sformatf("R7 flag vec%0d", v),
            66'(dup_err), 66'(t.exp_err));
        err_seen = 1'b1;
      end
      if (out_valid && out_ready) begin
        chk(out_cw == exp[cnt],
            $sformatf("%s/%s vec%0d slot%0d", tg,
                      (exp[cnt][65:64] == 2'b10) ? "R4" : "R5", v, cnt),
            out_cw, exp[cnt]);
        cnt++;
        stalled = 1'b0;
      end else if (out_valid) begin
        held = out_cw;
        stalled = 1'b1;
      end
      cyc++;
    end
    @(negedge clk);
    out_ready = 1'b0;
    chk(!out_valid && in_ready, $sformatf("R6 block end vec%0d", v),
        {64'h0, out_valid, in_ready}, 66'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0; in_blk = '0; in_bip = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    chk(!out_valid && in_ready && !dup_err, "R8 after reset",
        {63'h0, out_valid, in_ready, dup_err}, 66'h2);

    for (int v = 0; v < NV; v++) run_vec(VECS[v], v);

    // R8: reset in the middle of a block with the error flag set
    begin
      logic [BLKW-1:0] blk;
      logic [63:0]     bip;
      build(VECS[3], blk, bip);
      @(negedge clk);
      in_blk = blk; in_bip = bip; in_valid = 1'b1; out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk(!out_valid && in_ready && !dup_err, "R8 mid-block reset",
          {63'h0, out_valid, in_ready, dup_err}, 66'h2);
      rst = 1'b0;
      out_ready = 1'b0;
    end

    // recovery after reset with back-to-back blocks
    run_vec(VECS[2], 2);
    run_vec(VECS[6], 6);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule